// File: doc/BRIEF.md
# Ordered Multi-Class Transaction Dispatcher

This block sits on the outbound path of a bus bridge. It holds waiting transactions of five classes, each class in its own small queue, and picks which one to issue next. The choice follows a fixed, asymmetric permission matrix. A younger transaction may overtake an older transaction of another class only where the matrix allows it.

Every accepted transaction gets a relative arrival stamp from a wrap-around counter. Ages are compared with modular subtraction. A per-class stall input marks a destination that cannot take its class right now. The dispatcher may then issue a younger transaction of another class, but only if that class may pass every older pending entry. When nothing is stalled, issue is strictly oldest-first.

The enqueue side is a valid/ready port carrying a class code and a tag. The issue side is a valid/ready port returning the class and tag of the chosen entry.

Top module: `txn_order_dispatch`

## Requirements
- R1: After reset all queues are empty, the stamp counter is zero, `iss_valid` is low and `enq_ready` is high for any legal class code.
- R2: Class codes are 0 posted write/message, 1 read request, 2 configuration write request, 3 read completion, 4 configuration or I/O write completion. Codes 5 to 7 are refused with `enq_ready` low, and nothing is stored.
- R3: Each class holds 4 entries. When a class is full, `enq_ready` is low for that code, while other classes are still accepted.
- R4: Entries of one class are issued in the order they were accepted.
- R5: With every stall input low, entries are issued strictly oldest-first across all classes. A class whose stall input is high is never offered.
- R6: No entry is issued while an older posted write is still pending.
- R7: A posted write may be issued ahead of older read requests, configuration writes and completions.
- R8: A read request or configuration write is never issued ahead of an older read request or configuration write.
- R9: A read request or configuration write may be issued ahead of older completions of either type.
- R10: A completion of either type may be issued ahead of older read requests, configuration writes and completions, but never ahead of an older posted write.
- R11: An enqueue is refused while the stamp distance from the oldest pending entry to the next stamp has reached 31. With 6-bit stamps, 30 entries may follow a stuck oldest entry and the 31st is refused.
- R12: While `iss_valid` is high and `iss_ready` is low, the offered class and tag hold as long as the stall inputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request |
| enq_ready | output | 1 | Enqueue accepted this cycle |
| enq_class | input | 3 | Class code of the new entry |
| enq_tag | input | TAG_W | Payload tag of the new entry |
| iss_valid | output | 1 | An entry is offered for issue |
| iss_ready | input | 1 | Downstream takes the offered entry |
| iss_class | output | 3 | Class code of the offered entry |
| iss_tag | output | TAG_W | Tag of the offered entry |
| dest_stall | input | 5 | Per-class blocked destination, bit index = class code |

## Verification
The bench stalls each class in turn behind younger traffic of every other class.

- A matrix cell wired the wrong way shows up in two forms. In one, an entry leaks past a stalled posted write. In the other, the bench sees a read and a configuration write swap order, or an issue that should happen stays idle.
- A broken age compare shows up with no stalls at all, because issue order then departs from arrival order.
- A stuck completion is held while thirty posted writes stream past it. This exercises stamp wraparound and the refusal at the window edge. A design without that limit would accept the entry and then misorder it.
- Full-queue refusal, illegal codes and the hold of an unaccepted offer are checked at the ports.

// File: rtl/txn_disp_pkg.sv
package txn_disp_pkg;

    localparam int unsigned NUM_CLS = 5;
    localparam int unsigned CLS_W   = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_POSTED = 3'd0,
        CLS_RDREQ  = 3'd1,
        CLS_CFGWR  = 3'd2,
        CLS_RDCPL  = 3'd3,
        CLS_WRCPL  = 3'd4
    } txn_cls_e;

    // Returns 1 when a transaction of class 'younger' may be issued ahead of
    // an older pending transaction of class 'older'.
    function automatic logic may_overtake(input int unsigned younger, input int unsigned older);
        logic ok;
        ok = 1'b1;
        if (older == int'(CLS_POSTED)) begin
            ok = 1'b0;
        end else if ((younger == int'(CLS_RDREQ) || younger == int'(CLS_CFGWR)) &&
                     (older == int'(CLS_RDREQ) || older == int'(CLS_CFGWR))) begin
            ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/txn_cls_fifo.sv
module txn_cls_fifo #(
    parameter int unsigned DEPTH   = 4,
    parameter int unsigned TAG_W   = 8,
    parameter int unsigned STAMP_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [TAG_W-1:0]   push_tag,
    input  logic [STAMP_W-1:0] push_stamp,
    input  logic               pop,
    output logic               head_valid,
    output logic [TAG_W-1:0]   head_tag,
    output logic [STAMP_W-1:0] head_stamp,
    output logic               full
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0]   tag;
        logic [DEPTH-1:0][STAMP_W-1:0] stamp;
        logic [PTR_W-1:0]              rd;
        logic [PTR_W-1:0]              wr;
        logic [CNT_W-1:0]              cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.tag[st_q.wr]   = push_tag;
            st_d.stamp[st_q.wr] = push_stamp;
            st_d.wr             = ptr_inc(st_q.wr);
        end
        if (pop) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_valid = (st_q.cnt != '0);
    assign head_tag   = st_q.tag[st_q.rd];
    assign head_stamp = st_q.stamp[st_q.rd];
    assign full       = (st_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/txn_pass_arb.sv
module txn_pass_arb
    import txn_disp_pkg::*;
#(
    parameter int unsigned STAMP_W = 6
) (
    input  logic [NUM_CLS-1:0]              head_valid,
    input  logic [NUM_CLS-1:0][STAMP_W-1:0] head_stamp,
    input  logic [NUM_CLS-1:0]              blocked,
    output logic [NUM_CLS-1:0]              grant,
    output logic [NUM_CLS-1:0]              oldest
);

    // a is older than b when b - a is nonzero and in the lower half of the ring
    function automatic logic older_than(input logic [STAMP_W-1:0] a, input logic [STAMP_W-1:0] b);
        logic [STAMP_W-1:0] diff;
        diff = b - a;
        return (diff != '0) && !diff[STAMP_W-1];
    endfunction

    logic [NUM_CLS-1:0] eligible;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_elig
        always_comb begin
            logic ok_v;
            logic top_v;
            ok_v  = head_valid[c] && !blocked[c];
            top_v = head_valid[c];
            for (int k = 0; k < NUM_CLS; k++) begin
                if (k != c && head_valid[k] && older_than(head_stamp[k], head_stamp[c])) begin
                    top_v = 1'b0;
                    if (!may_overtake(c, k)) begin
                        ok_v = 1'b0;
                    end
                end
            end
            eligible[c] = ok_v;
            oldest[c]   = top_v;
        end
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_grant
        always_comb begin
            logic win_v;
            win_v = eligible[c];
            for (int k = 0; k < NUM_CLS; k++) begin
                if (k != c && eligible[k] && older_than(head_stamp[k], head_stamp[c])) begin
                    win_v = 1'b0;
                end
            end
            grant[c] = win_v;
        end
    end

endmodule

// File: rtl/txn_order_dispatch.sv
module txn_order_dispatch
    import txn_disp_pkg::*;
#(
    parameter int unsigned DEPTH   = 4,
    parameter int unsigned TAG_W   = 8,
    parameter int unsigned STAMP_W = $clog2(NUM_CLS * DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    output logic             enq_ready,
    input  logic [CLS_W-1:0] enq_class,
    input  logic [TAG_W-1:0] enq_tag,
    output logic             iss_valid,
    input  logic             iss_ready,
    output logic [CLS_W-1:0] iss_class,
    output logic [TAG_W-1:0] iss_tag,
    input  logic [NUM_CLS-1:0] dest_stall
);

    localparam logic [STAMP_W-1:0] SPAN_LIMIT = STAMP_W'((2 ** (STAMP_W - 1)) - 1);

    typedef struct packed {
        logic [STAMP_W-1:0] stamp;
    } disp_st_t;

    disp_st_t st_d, st_q;

    logic [NUM_CLS-1:0]              push;
    logic [NUM_CLS-1:0]              pop;
    logic [NUM_CLS-1:0]              head_valid;
    logic [NUM_CLS-1:0][TAG_W-1:0]   head_tag;
    logic [NUM_CLS-1:0][STAMP_W-1:0] head_stamp;
    logic [NUM_CLS-1:0]              full;
    logic [NUM_CLS-1:0]              grant;
    logic [NUM_CLS-1:0]              oldest;

    logic               class_legal;
    logic               class_full;
    logic               window_ok;
    logic [STAMP_W-1:0] oldest_stamp;
    logic [STAMP_W-1:0] span;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_queue
        txn_cls_fifo #(
            .DEPTH   (DEPTH),
            .TAG_W   (TAG_W),
            .STAMP_W (STAMP_W)
        ) i_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (push[c]),
            .push_tag   (enq_tag),
            .push_stamp (st_q.stamp),
            .pop        (pop[c]),
            .head_valid (head_valid[c]),
            .head_tag   (head_tag[c]),
            .head_stamp (head_stamp[c]),
            .full       (full[c])
        );
    end

    txn_pass_arb #(
        .STAMP_W (STAMP_W)
    ) i_arb (
        .head_valid (head_valid),
        .head_stamp (head_stamp),
        .blocked    (dest_stall),
        .grant      (grant),
        .oldest     (oldest)
    );

    // Enqueue side: class decode, full check, stamp window
    always_comb begin
        class_legal  = 1'b0;
        class_full   = 1'b0;
        oldest_stamp = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (enq_class == CLS_W'(c)) begin
                class_legal = 1'b1;
                class_full  = full[c];
            end
            if (oldest[c]) begin
                oldest_stamp = oldest_stamp | head_stamp[c];
            end
        end
        span      = st_q.stamp - oldest_stamp;
        window_ok = (head_valid == '0) || (span < SPAN_LIMIT);
        enq_ready = class_legal && !class_full && window_ok;
        for (int c = 0; c < NUM_CLS; c++) begin
            push[c] = enq_valid && enq_ready && (enq_class == CLS_W'(c));
        end
    end

    // Issue side: one-hot grant selects class and tag
    always_comb begin
        iss_valid = |grant;
        iss_class = '0;
        iss_tag   = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            pop[c] = grant[c] && iss_ready;
            if (grant[c]) begin
                iss_class = CLS_W'(c);
                iss_tag   = head_tag[c];
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.stamp = st_q.stamp + STAMP_W'(|push);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/txn_order_dispatch_chk.sv
module txn_order_dispatch_chk
    import txn_disp_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned TAG_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enq_valid,
    input logic               enq_ready,
    input logic [CLS_W-1:0]   enq_class,
    input logic               iss_valid,
    input logic               iss_ready,
    input logic [CLS_W-1:0]   iss_class,
    input logic [TAG_W-1:0]   iss_tag,
    input logic [NUM_CLS-1:0] dest_stall
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1) + 1;

    logic [NUM_CLS-1:0][CNT_W-1:0] outst;
    logic enq_cls_full;
    logic iss_cls_stalled;
    logic iss_cls_legal;
    logic all_empty;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                outst[c] <= '0;
            end else begin
                outst[c] <= outst[c]
                          + CNT_W'(enq_valid && enq_ready && enq_class == CLS_W'(c))
                          - CNT_W'(iss_valid && iss_ready && iss_class == CLS_W'(c));
            end
        end
    end

    always_comb begin
        enq_cls_full    = 1'b0;
        iss_cls_stalled = 1'b0;
        iss_cls_legal   = 1'b0;
        all_empty       = 1'b1;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (enq_class == CLS_W'(c) && outst[c] == CNT_W'(DEPTH)) enq_cls_full = 1'b1;
            if (iss_class == CLS_W'(c)) begin
                iss_cls_legal   = 1'b1;
                iss_cls_stalled = dest_stall[c];
            end
            if (outst[c] != '0) all_empty = 1'b0;
        end
    end

    // R1
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_empty |-> !iss_valid);

    // R2
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_ready) |-> (enq_class < CLS_W'(NUM_CLS)));

    // R3
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enq_cls_full |-> !enq_ready);

    // R5
    no_stalled_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_cls_legal && !iss_cls_stalled));

    // R12
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=>
            ((iss_valid && $stable(iss_tag) && $stable(iss_class)) || !$stable(dest_stall)));

endmodule

bind txn_order_dispatch txn_order_dispatch_chk #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_valid  (enq_valid),
    .enq_ready  (enq_ready),
    .enq_class  (enq_class),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .iss_class  (iss_class),
    .iss_tag    (iss_tag),
    .dest_stall (dest_stall)
);

// File: tb/test_txn_order_dispatch.sv
module test_txn_order_dispatch;

    localparam logic [2:0] PW = 3'd0;
    localparam logic [2:0] RD = 3'd1;
    localparam logic [2:0] CW = 3'd2;
    localparam logic [2:0] RC = 3'd3;
    localparam logic [2:0] WC = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       enq_valid;
    logic       enq_ready;
    logic [2:0] enq_class;
    logic [7:0] enq_tag;
    logic       iss_valid;
    logic       iss_ready;
    logic [2:0] iss_class;
    logic [7:0] iss_tag;
    logic [4:0] dest_stall;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    txn_order_dispatch i_txn_order_dispatch (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq_valid  (enq_valid),
        .enq_ready  (enq_ready),
        .enq_class  (enq_class),
        .enq_tag    (enq_tag),
        .iss_valid  (iss_valid),
        .iss_ready  (iss_ready),
        .iss_class  (iss_class),
        .iss_tag    (iss_tag),
        .dest_stall (dest_stall)
    );

    task automatic check_val(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n      = 1'b0;
        enq_valid  = 1'b0;
        enq_class  = '0;
        enq_tag    = '0;
        iss_ready  = 1'b0;
        dest_stall = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic enq(input logic [2:0] cls, input logic [7:0] tag, input bit exp_acc, input string req);
        @(negedge clk);
        enq_valid = 1'b1;
        enq_class = cls;
        enq_tag   = tag;
        #1;
        check_val(req, "enq_ready", int'(enq_ready), int'(exp_acc));
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic take(input logic [2:0] cls, input logic [7:0] tag, input string req);
        @(negedge clk);
        #1;
        check_val(req, "iss_valid", int'(iss_valid), 1);
        check_val(req, "iss_class", int'(iss_class), int'(cls));
        check_val(req, "iss_tag", int'(iss_tag), int'(tag));
        iss_ready = 1'b1;
        @(negedge clk);
        iss_ready = 1'b0;
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        #1;
        check_val(req, "iss_valid idle", int'(iss_valid), 0);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        enq_class = RD;
        #1;
        check_val("R1", "iss_valid after reset", int'(iss_valid), 0);
        check_val("R1", "enq_ready after reset", int'(enq_ready), 1);
    endtask

    task automatic t_codes();
        do_reset();
        for (int code = 5; code < 8; code++) begin
            enq(3'(code), 8'h01, 1'b0, "R2");
        end
        idle("R2");
        enq(WC, 8'h02, 1'b1, "R2");
        take(WC, 8'h02, "R2");
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < 4; i++) enq(RD, 8'(8'h11 + i), 1'b1, "R3");
        enq(RD, 8'h19, 1'b0, "R3");
        enq(PW, 8'h1A, 1'b1, "R3");
        // R4: same-class order, then the younger posted write
        for (int i = 0; i < 4; i++) take(RD, 8'(8'h11 + i), "R4");
        take(PW, 8'h1A, "R4");
        idle("R4");
    endtask

    task automatic t_oldest();
        do_reset();
        enq(RC, 8'h21, 1'b1, "R5");
        enq(PW, 8'h22, 1'b1, "R5");
        enq(WC, 8'h23, 1'b1, "R5");
        enq(CW, 8'h24, 1'b1, "R5");
        enq(RD, 8'h25, 1'b1, "R5");
        enq(RC, 8'h26, 1'b1, "R5");
        take(RC, 8'h21, "R5");
        take(PW, 8'h22, "R5");
        take(WC, 8'h23, "R5");
        take(CW, 8'h24, "R5");
        take(RD, 8'h25, "R5");
        take(RC, 8'h26, "R5");
    endtask

    task automatic t_pw_block();
        do_reset();
        enq(PW, 8'h31, 1'b1, "R6");
        enq(RD, 8'h32, 1'b1, "R6");
        enq(CW, 8'h33, 1'b1, "R6");
        enq(RC, 8'h34, 1'b1, "R6");
        enq(WC, 8'h35, 1'b1, "R6");
        dest_stall = 5'b00001;
        idle("R6");
        idle("R6");
        dest_stall = '0;
        take(PW, 8'h31, "R6");
        take(RD, 8'h32, "R6");
        take(CW, 8'h33, "R6");
        take(RC, 8'h34, "R6");
        take(WC, 8'h35, "R6");
    endtask

    task automatic t_pw_pass();
        do_reset();
        enq(RD, 8'h41, 1'b1, "R7");
        enq(CW, 8'h42, 1'b1, "R7");
        enq(RC, 8'h43, 1'b1, "R7");
        enq(WC, 8'h44, 1'b1, "R7");
        enq(PW, 8'h45, 1'b1, "R7");
        dest_stall = 5'b11110;
        take(PW, 8'h45, "R7");
        idle("R7");
        dest_stall = '0;
        take(RD, 8'h41, "R7");
        take(CW, 8'h42, "R7");
        take(RC, 8'h43, "R7");
        take(WC, 8'h44, "R7");
    endtask

    task automatic t_rdcw();
        do_reset();
        enq(RD, 8'h51, 1'b1, "R8");
        enq(CW, 8'h52, 1'b1, "R8");
        dest_stall = 5'b00010;
        idle("R8");
        dest_stall = '0;
        take(RD, 8'h51, "R8");
        take(CW, 8'h52, "R8");
        enq(CW, 8'h53, 1'b1, "R8");
        enq(RD, 8'h54, 1'b1, "R8");
        dest_stall = 5'b00100;
        idle("R8");
        dest_stall = '0;
        take(CW, 8'h53, "R8");
        take(RD, 8'h54, "R8");
    endtask

    task automatic t_rdcw_pass();
        do_reset();
        enq(RC, 8'h61, 1'b1, "R9");
        enq(WC, 8'h62, 1'b1, "R9");
        enq(RD, 8'h63, 1'b1, "R9");
        enq(CW, 8'h64, 1'b1, "R9");
        dest_stall = 5'b11000;
        take(RD, 8'h63, "R9");
        take(CW, 8'h64, "R9");
        dest_stall = '0;
        take(RC, 8'h61, "R9");
        take(WC, 8'h62, "R9");
    endtask

    task automatic t_cpl();
        do_reset();
        enq(RD, 8'h71, 1'b1, "R10");
        enq(CW, 8'h72, 1'b1, "R10");
        enq(WC, 8'h73, 1'b1, "R10");
        enq(RC, 8'h74, 1'b1, "R10");
        dest_stall = 5'b00110;
        take(WC, 8'h73, "R10");
        take(RC, 8'h74, "R10");
        enq(WC, 8'h75, 1'b1, "R10");
        enq(RC, 8'h76, 1'b1, "R10");
        dest_stall = 5'b10110;
        take(RC, 8'h76, "R10");
        dest_stall = '0;
        take(RD, 8'h71, "R10");
        take(CW, 8'h72, "R10");
        take(WC, 8'h75, "R10");
        enq(PW, 8'h77, 1'b1, "R10");
        enq(RC, 8'h78, 1'b1, "R10");
        enq(WC, 8'h79, 1'b1, "R10");
        dest_stall = 5'b00001;
        idle("R10");
        dest_stall = '0;
        take(PW, 8'h77, "R10");
        take(RC, 8'h78, "R10");
        take(WC, 8'h79, "R10");
    endtask

    task automatic t_window();
        do_reset();
        dest_stall = 5'b01000;
        enq(RC, 8'h81, 1'b1, "R11");
        for (int i = 0; i < 30; i++) begin
            enq(PW, 8'(i), 1'b1, "R11");
            take(PW, 8'(i), "R11");
        end
        enq(PW, 8'hE0, 1'b0, "R11");
        idle("R11");
        dest_stall = '0;
        take(RC, 8'h81, "R11");
        enq(PW, 8'hE1, 1'b1, "R11");
        take(PW, 8'hE1, "R11");
    endtask

    task automatic t_hold();
        do_reset();
        enq(RD, 8'h91, 1'b1, "R12");
        enq(PW, 8'h92, 1'b1, "R12");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            check_val("R12", "held iss_valid", int'(iss_valid), 1);
            check_val("R12", "held iss_tag", int'(iss_tag), 8'h91);
        end
        take(RD, 8'h91, "R12");
        take(PW, 8'h92, "R12");
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_codes();
        t_full();
        t_oldest();
        t_pw_block();
        t_pw_pass();
        t_rdcw();
        t_rdcw_pass();
        t_cpl();
        t_window();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule